// File: doc/BRIEF.md
# Test Access Port with Field-Decoded 25-Bit Instruction

This block is a boundary-scan style test access port. It runs the standard sixteen-state TAP controller from TCK and TMS, holds a 25-bit instruction, and puts one data register between TDI and TDO. Several fields of the active instruction drive chip-test controls directly. Most of these controls are active low.

Bit 24 of the instruction chooses what the data path connects to. When bit 24 is low, the block routes the data path out to an external scan chain, and bits 23:18 name that chain. When bit 24 is high, the full word is decoded to one of five internal registers:

- a bypass bit
- a 32-bit identification word
- an 8-bit revision
- an 8-bit read/write mode register
- a 1-bit register that also raises a tristate/compare request

Any other word with bit 24 high uses the bypass bit. The internal chains, BIST engines and pad cells are not part of this block. They connect only through the chain data return and the control outputs.

Top module: `tap_ctrl25`

## Requirements
- R1: The controller samples TMS on rising TCK and follows the sixteen-state TAP graph. Five rising edges with TMS high reach Test-Logic-Reset from any state. trst_n low forces Test-Logic-Reset at once, without waiting for a clock.
- R2: While in Test-Logic-Reset, the active instruction is 1FFFFFEh. The mode register is cleared to 00h, and test_mode_n, out_hiz_n, bsr_pad_n and bsr_core_n are all 1.
- R3: Capture-IR loads the instruction shift register with bit 0 = 1 and all other bits 0. Shift-IR moves it toward TDO, least significant bit first.
- R4: A shifted instruction becomes active only on the falling TCK edge in Update-IR. Every decoded output keeps its old value during Shift-IR and on the rising edge into Update-IR.
- R5: Instruction 1FFFFFEh selects a 32-bit register that captures 0D5A1003h. Its bits shift out least significant bit first.
- R6: Instruction 127FFFAh selects an 8-bit register that captures 10h (major revision in the upper nibble, minor revision in the lower nibble).
- R7: Instruction 123FFFAh selects the 8-bit mode register. Capture-DR loads its current value. On the falling edge in Update-DR, the register takes the last 8 bits that were shifted in. The register is visible on mode_val.
- R8: Instruction 1FFFFDFh selects a 1-bit register that captures 0. hiz_cmp is 1 exactly while this instruction is active.
- R9: Instruction 1FFFFFFh selects a 1-bit bypass register that captures 0. Any other word with bit 24 high that is not listed in R5 to R8 also selects it. Through this register, TDO repeats TDI one bit later.
- R10: While instruction bit 24 is 0, chain_sel equals bits 23:18 and chain_shift is 1 in Shift-DR. During that shift, TDO carries chain_tdo.
- R11: The control outputs come straight from the active instruction:
  - test_mode_n = bit 6
  - out_hiz_n = bit 5
  - bsr_pad_n = bit 4
  - bsr_core_n = bit 3
  - chain_op = bits 2:0
  - bist_en = {bits 17:16, bits 9:7}
- R12: TDO and tdo_oe change only on falling TCK. tdo_oe is 1 only after a falling edge in Shift-IR or Shift-DR. At all other times tdo is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tdo_oe | output | 1 | TDO drive enable, high while shifting |
| chain_tdo | input | 1 | Return data from the selected external scan chain |
| chain_sel | output | 6 | External chain number from the instruction |
| chain_shift | output | 1 | External chain shifts this cycle |
| chain_op | output | 3 | Chain wiring opcode |
| bist_en | output | 5 | BIST chain enable field |
| test_mode_n | output | 1 | Scan test mode, active low |
| out_hiz_n | output | 1 | Force all outputs tristate, active low |
| bsr_pad_n | output | 1 | Boundary cells drive pads, active low |
| bsr_core_n | output | 1 | Boundary cells drive core, active low |
| hiz_cmp | output | 1 | Tristate/compare instruction active |
| mode_val | output | 8 | Mode register contents |

## Verification
Every data scan shifts the selected register's length plus eight bits of random data. The leading bits therefore show the captured constant, and the trailing bits show the register length. This is the only way to tell the 1-bit, 8-bit and 32-bit paths apart. Instruction words are drawn from the five listed codes, from unlisted words with bit 24 high, and from chain words with bit 24 low. These three groups separate exact decoding from the bypass fallback and from external routing, and each word also exercises the field-to-control mapping. Directed cases cover:
- entering reset through TMS and through trst_n, with the mode register written beforehand;
- the value of the control outputs on the edge into Update-IR;
- a mode write followed by a read-back.

// File: rtl/tap_ctrl25.sv
module tap_ctrl25 #(
  parameter logic [31:0] ID_CODE  = 32'h0D5A1003,
  parameter logic [7:0]  REV_CODE = 8'h10
) (
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  input  logic       tdi,
  output logic       tdo,
  output logic       tdo_oe,
  input  logic       chain_tdo,
  output logic [5:0] chain_sel,
  output logic       chain_shift,
  output logic [2:0] chain_op,
  output logic [4:0] bist_en,
  output logic       test_mode_n,
  output logic       out_hiz_n,
  output logic       bsr_pad_n,
  output logic       bsr_core_n,
  output logic       hiz_cmp,
  output logic [7:0] mode_val
);
  localparam int IR_W = 25;
  localparam int DR_W = 32;
  localparam logic [IR_W-1:0] OP_BYP  = 25'h1FFFFFF;
  localparam logic [IR_W-1:0] OP_ID   = 25'h1FFFFFE;
  localparam logic [IR_W-1:0] OP_REV  = 25'h127FFFA;
  localparam logic [IR_W-1:0] OP_MODE = 25'h123FFFA;
  localparam logic [IR_W-1:0] OP_HIZ  = 25'h1FFFFDF;

  typedef enum logic [3:0] {
    TLR, RTI, SEL_DR, CAP_DR, SH_DR, EX1_DR, PAU_DR, EX2_DR, UPD_DR,
    SEL_IR, CAP_IR, SH_IR, EX1_IR, PAU_IR, EX2_IR, UPD_IR
  } tap_st_t;

  typedef enum logic [2:0] {D_BYP, D_ID, D_REV, D_MODE, D_HIZ, D_CHAIN} dsel_t;

  tap_st_t st, st_nx;
  logic [IR_W-1:0] ir_sr, ir;
  logic [DR_W-1:0] dr_sr, dr_nx, dr_sh;
  logic [7:0] mode_q;
  logic [4:0] dr_last;
  dsel_t dsel;
  logic tdo_q, oe_q;

  always_comb begin
    case (st)
      TLR:    st_nx = tms ? TLR    : RTI;
      RTI:    st_nx = tms ? SEL_DR : RTI;
      SEL_DR: st_nx = tms ? SEL_IR : CAP_DR;
      CAP_DR: st_nx = tms ? EX1_DR : SH_DR;
      SH_DR:  st_nx = tms ? EX1_DR : SH_DR;
      EX1_DR: st_nx = tms ? UPD_DR : PAU_DR;
      PAU_DR: st_nx = tms ? EX2_DR : PAU_DR;
      EX2_DR: st_nx = tms ? UPD_DR : SH_DR;
      UPD_DR: st_nx = tms ? SEL_DR : RTI;
      SEL_IR: st_nx = tms ? TLR    : CAP_IR;
      CAP_IR: st_nx = tms ? EX1_IR : SH_IR;
      SH_IR:  st_nx = tms ? EX1_IR : SH_IR;
      EX1_IR: st_nx = tms ? UPD_IR : PAU_IR;
      PAU_IR: st_nx = tms ? EX2_IR : PAU_IR;
      EX2_IR: st_nx = tms ? UPD_IR : SH_IR;
      default: st_nx = tms ? SEL_DR : RTI;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n) st <= TLR;
    else         st <= st_nx;

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n)           ir_sr <= '0;
    else if (st == CAP_IR) ir_sr <= {{(IR_W-2){1'b0}}, 2'b01};
    else if (st == SH_IR)  ir_sr <= {tdi, ir_sr[IR_W-1:1]};

  always_ff @(negedge tck or negedge trst_n)
    if (!trst_n)           ir <= OP_ID;
    else if (st == TLR)    ir <= OP_ID;
    else if (st == UPD_IR) ir <= ir_sr;

  always_comb begin
    if (!ir[IR_W-1])       dsel = D_CHAIN;
    else if (ir == OP_ID)   dsel = D_ID;
    else if (ir == OP_REV)  dsel = D_REV;
    else if (ir == OP_MODE) dsel = D_MODE;
    else if (ir == OP_HIZ)  dsel = D_HIZ;
    else                    dsel = D_BYP;
    case (dsel)
      D_ID:           dr_last = 5'(DR_W - 1);
      D_REV, D_MODE:  dr_last = 5'd7;
      default:        dr_last = 5'd0;
    endcase
  end

  assign dr_sh = {1'b0, dr_sr[DR_W-1:1]};
  always_comb
    for (int i = 0; i < DR_W; i++)
      dr_nx[i] = (5'(i) == dr_last) ? tdi : dr_sh[i];

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n) dr_sr <= '0;
    else if (st == CAP_DR)
      case (dsel)
        D_ID:    dr_sr <= ID_CODE;
        D_REV:   dr_sr <= {{(DR_W-8){1'b0}}, REV_CODE};
        D_MODE:  dr_sr <= {{(DR_W-8){1'b0}}, mode_q};
        default: dr_sr <= '0;
      endcase
    else if (st == SH_DR) dr_sr <= dr_nx;

  always_ff @(negedge tck or negedge trst_n)
    if (!trst_n)                            mode_q <= '0;
    else if (st == TLR)                     mode_q <= '0;
    else if (st == UPD_DR && dsel == D_MODE) mode_q <= dr_sr[7:0];

  always_ff @(negedge tck or negedge trst_n)
    if (!trst_n) begin
      tdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      oe_q  <= (st == SH_IR) || (st == SH_DR);
      tdo_q <= (st == SH_IR) ? ir_sr[0] :
               (st == SH_DR) ? ((dsel == D_CHAIN) ? chain_tdo : dr_sr[0]) : 1'b0;
    end

  assign tdo         = tdo_q;
  assign tdo_oe      = oe_q;
  assign chain_sel   = ir[23:18];
  assign chain_shift = (dsel == D_CHAIN) && (st == SH_DR);
  assign chain_op    = ir[2:0];
  assign bist_en     = {ir[17:16], ir[9:7]};
  assign test_mode_n = ir[6];
  assign out_hiz_n   = ir[5];
  assign bsr_pad_n   = ir[4];
  assign bsr_core_n  = ir[3];
  assign hiz_cmp     = (ir == OP_HIZ);
  assign mode_val    = mode_q;

  // R12
  oe_only_shift_chk: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe |-> (st == SH_IR || st == SH_DR));

  // R2
  reset_ctl_high_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (st == TLR && $past(st) == TLR) |->
      ({test_mode_n, out_hiz_n, bsr_pad_n, bsr_core_n} == 4'hF && mode_val == 8'h00));

  // R4
  ir_update_only_chk: assert property (@(posedge tck) disable iff (!trst_n)
    !$stable(chain_sel) |-> (st == UPD_IR || st == TLR));

  // R7
  mode_write_only_chk: assert property (@(posedge tck) disable iff (!trst_n)
    !$stable(mode_val) |-> ((st == UPD_DR && dsel == D_MODE) || st == TLR));
endmodule

// File: tb/tb_tap_ctrl25.sv
module tb_tap_ctrl25;
  localparam int TCK_P = 20;
  localparam logic [24:0] I_BYP  = 25'h1FFFFFF;
  localparam logic [24:0] I_ID   = 25'h1FFFFFE;
  localparam logic [24:0] I_REV  = 25'h127FFFA;
  localparam logic [24:0] I_MODE = 25'h123FFFA;
  localparam logic [24:0] I_HIZ  = 25'h1FFFFDF;

  logic tck = 0, trst_n = 0, tms = 1, tdi = 0, chain_tdo = 0;
  logic tdo, tdo_oe, chain_shift, test_mode_n, out_hiz_n, bsr_pad_n, bsr_core_n, hiz_cmp;
  logic [5:0] chain_sel;
  logic [2:0] chain_op;
  logic [4:0] bist_en;
  logic [7:0] mode_val;

  int checks = 0, errors = 0;
  logic last_oe, last_cs, dummy;
  logic [7:0] m_mode = 8'h00;
  logic [24:0] m_ir = I_ID;
  int unsigned seed = 32'd1234;

  tap_ctrl25 dut (.tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .chain_tdo(chain_tdo), .chain_sel(chain_sel), .chain_shift(chain_shift), .chain_op(chain_op),
    .bist_en(bist_en), .test_mode_n(test_mode_n), .out_hiz_n(out_hiz_n), .bsr_pad_n(bsr_pad_n),
    .bsr_core_n(bsr_core_n), .hiz_cmp(hiz_cmp), .mode_val(mode_val));

  initial forever #(TCK_P/2) tck = ~tck;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int e_len(input logic [24:0] x);
    if (x == I_ID) return 32;
    if (x == I_REV || x == I_MODE) return 8;
    return 1;
  endfunction

  function automatic logic [31:0] e_cap(input logic [24:0] x, input logic [7:0] m);
    if (x == I_ID) return 32'h0D5A1003;
    if (x == I_REV) return 32'h10;
    if (x == I_MODE) return {24'h0, m};
    return 32'h0;
  endfunction

  function automatic logic [18:0] e_ctl(input logic [24:0] x);
    return {x[6], x[5], x[4], x[3], x[2:0], x[17:16], x[9:7], x[23:18], x == I_HIZ};
  endfunction

  function automatic logic [18:0] ctl();
    return {test_mode_n, out_hiz_n, bsr_pad_n, bsr_core_n, chain_op, bist_en, chain_sel, hiz_cmp};
  endfunction

  task automatic step(input logic m, input logic d, output logic seen);
    @(negedge tck); #1;
    seen = tdo; last_oe = tdo_oe; last_cs = chain_shift;
    tms = m; tdi = d;
    @(posedge tck);
  endtask

  task automatic do_ir(input logic [24:0] x);
    logic [24:0] o = '0;
    step(1, 0, dummy); step(1, 0, dummy); step(0, 0, dummy); step(0, 0, dummy);
    for (int i = 0; i < 25; i++) step(i == 24, x[i], o[i]);
    check("R3 capture-IR pattern", 64'(o), 64'h1);
    check("R12 tdo_oe in Shift-IR", 64'(last_oe), 64'h1);
    step(1, 0, dummy); step(0, 0, dummy);
    m_ir = x;
    check("R11 control fields", 64'(ctl()), 64'(e_ctl(x)));
  endtask

  task automatic test_dr(input string req, input logic [63:0] din, input logic c);
    int len = e_len(m_ir);
    int n = (m_ir[24] ? len : 8) + 8;
    logic [63:0] o = '0, ex = '0;
    logic oe0 = 0, cs0 = 0;
    chain_tdo = c;
    step(1, 0, dummy); step(0, 0, dummy); step(0, 0, dummy);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i], o[i]);
      if (i == 0) begin oe0 = last_oe; cs0 = last_cs; end
    end
    step(1, 0, dummy); step(0, 0, dummy);
    for (int i = 0; i < n; i++)
      ex[i] = !m_ir[24] ? c : (i < len) ? e_cap(m_ir, m_mode)[i] : din[i-len];
    check(req, o, ex);
    check("R12 tdo_oe in Shift-DR", 64'(oe0), 64'h1);
    check("R10 chain_shift", 64'(cs0), 64'(!m_ir[24]));
    if (m_ir == I_MODE) m_mode = din[15:8];
    check("R7 mode_val", 64'(mode_val), 64'(m_mode));
  endtask

  initial begin
    #(TCK_P * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(seed));
    #(TCK_P * 3);
    check("R2 reset controls", 64'(ctl()), 64'(e_ctl(I_ID)));
    check("R2 reset mode", 64'(mode_val), 64'h0);
    check("R12 reset tdo", 64'({tdo_oe, tdo}), 64'h0);
    @(negedge tck); trst_n = 1;
    step(0, 0, dummy);
    @(negedge tck); #1;
    check("R12 idle tdo_oe", 64'({tdo_oe, tdo}), 64'h0);
    test_dr("R5 id capture", 64'hA5, 0);
    do_ir(I_REV);  test_dr("R6 revision", 64'h3C, 0);
    do_ir(I_MODE); test_dr("R7 mode write", 64'h5AA5, 0); test_dr("R7 mode read", 64'h0F0F, 0);
    do_ir(I_HIZ);  test_dr("R8 hiz register", 64'hE7, 0);
    do_ir(I_BYP);  test_dr("R9 bypass", 64'h96, 1);
    do_ir(25'h1FFFFF0); test_dr("R9 unknown falls back", 64'h69, 0);
    do_ir(25'h0A95555); test_dr("R10 chain path", 64'h33, 1);

    // R4: old outputs held until falling edge in Update-IR
    do_ir(I_ID);
    step(1, 0, dummy); step(1, 0, dummy); step(0, 0, dummy); step(0, 0, dummy);
    for (int i = 0; i < 25; i++) begin
      step(i == 24, I_HIZ[i], dummy);
      if (i == 12) check("R4 held in Shift-IR", 64'(hiz_cmp), 64'h0);
    end
    step(1, 0, dummy); #1;
    check("R4 held at Update-IR rise", 64'(ctl()), 64'(e_ctl(I_ID)));
    step(0, 0, dummy); m_ir = I_HIZ;
    check("R4 applied after Update-IR", 64'(hiz_cmp), 64'h1);

    // R1: five TMS-high clocks from Shift-DR
    do_ir(I_MODE); test_dr("R7 mode write", 64'hC3C3, 0);
    step(1, 0, dummy); step(0, 0, dummy); step(0, 0, dummy);
    for (int i = 0; i < 5; i++) step(1, 0, dummy);
    step(0, 0, dummy);
    m_ir = I_ID; m_mode = 8'h00;
    check("R1 tms reset controls", 64'(ctl()), 64'(e_ctl(I_ID)));
    check("R1 tms reset mode", 64'(mode_val), 64'h0);
    test_dr("R1 id after tms reset", 64'h11, 0);

    // R1: asynchronous trst_n in mid-scan
    do_ir(I_MODE); test_dr("R7 mode write", 64'h7E7E, 0);
    do_ir(I_HIZ);
    step(1, 0, dummy); step(0, 0, dummy); step(0, 0, dummy);
    #3; trst_n = 0; #1;
    m_ir = I_ID; m_mode = 8'h00;
    check("R1 trst async controls", 64'(ctl()), 64'(e_ctl(I_ID)));
    check("R1 trst async mode", 64'(mode_val), 64'h0);
    @(negedge tck); trst_n = 1; tms = 0;
    step(0, 0, dummy);
    test_dr("R5 id after trst", 64'h2D, 0);

    for (int k = 0; k < 60; k++) begin
      logic [24:0] x;
      int unsigned r = $urandom % 7;
      case (r)
        0: x = I_BYP; 1: x = I_ID; 2: x = I_REV; 3: x = I_MODE; 4: x = I_HIZ;
        5: x = {1'b1, 24'($urandom)};
        default: x = {1'b0, 24'($urandom)};
      endcase
      do_ir(x);
      test_dr("R9 random data path", {$urandom, $urandom}, 1'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule